// File: doc/BRIEF.md
# SPI Slave with Select-Abort Retry

This block is a serial peripheral slave. An external master supplies the serial clock. Each word is shifted most significant bit first: bits come in on the data input and leave on the data output. The host side loads the next outgoing word into a one-word transmit holding buffer. It collects the incoming word from a one-word receive buffer. Two configuration bits choose the idle level of the serial clock and whether data is sampled on the leading or the trailing clock edge. A two-bit field chooses a word length of 8, 16 or 32 bits.

Slave-select synchronisation is optional. When it is enabled, bits move only while the active-low select is held low. The output driver is released whenever select is high. A word cut short by select rising is discarded and is sent again from the start, from the word still held in the transmit buffer. The transmit-empty flag then stays low until the whole word has been sent. When the option is off, select is ignored. In that case the holding buffer is freed as soon as the word enters the shifter.

The serial clock, select and data input each pass through a two-flop synchroniser into the system clock domain. The serial clock must be at most one quarter of the system clock frequency.

Top module: `spi_slave_sel`

## Requirements
- R1: After reset, tx_empty=1, rx_full=0, rx_ovr=0, and with sel_en=0 sdo_en=1.
- R2: With cpol giving the idle level of sck, a leading edge leaves the idle level and a trailing edge returns to it. cke=1 samples sdi on leading edges and cke=0 on trailing edges; sdo changes on the other edge. Words go MSB first. wlen=0 gives 8 bits, wlen=1 gives 16, and wlen=2 or 3 gives 32. The received word sits right-justified in rx_data with the upper bits zero.
- R3: With sel_en=1 and ss_n high, sdo_en=0, and sck edges neither shift data nor change any flag.
- R4: With sel_en=1, ss_n rising in mid-word drops the partial word. rx_data, rx_full and rx_ovr are unchanged. On the next ss_n low the same transmit word is sent again from its first bit.
- R5: With sel_en=1, tx_empty stays 0 from a host load until the last bit of that word is sampled. With sel_en=0, tx_empty returns to 1 at the first sample edge of the word.
- R6: With sel_en=0, ss_n has no effect: sdo_en stays 1 and transfers continue.
- R7: At word completion, if rx_full=0 the word is stored and rx_full becomes 1. If rx_full=1, rx_ovr becomes 1 and rx_data keeps the old word.
- R8: A host read (rx_rd) in the same cycle as a word completion is applied first. The new word is stored, rx_full stays 1, and no overrun is flagged.
- R9: A tx_wr while tx_empty=0 is ignored.
- R10: If the transmit buffer is empty when a word starts, all zeros are shifted out.
- R11: rx_rd clears rx_full, and ovr_clr clears rx_ovr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Idle level of sck |
| cke | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| wlen | input | 2 | Word length select (0:8, 1:16, 2/3:32) |
| sel_en | input | 1 | Enables slave-select synchronisation |
| tx_wr | input | 1 | Host load strobe for the transmit buffer |
| tx_data | input | 32 | Word to transmit, right-justified |
| rx_rd | input | 1 | Host read strobe, clears rx_full |
| ovr_clr | input | 1 | Clears rx_ovr |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for sdo (0 = high impedance) |
| rx_data | output | 32 | Last received word, right-justified |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_ovr | output | 1 | A word completed while rx_full was set |
| tx_empty | output | 1 | Transmit buffer may be loaded |

## Verification
A word completion and a host read of the receive buffer can fall in the same system cycle. Whichever is taken first decides whether the new word is lost to an overrun. The bench provokes this by counting the three synchroniser and edge-detect stages after it drives the final sampling edge of sck. It then pulses rx_rd for exactly the cycle in which the completion is registered. It judges the result by requiring rx_full=1, rx_ovr=0 and rx_data equal to the new word. Select-abort mid-word, writes into a full buffer and overruns are also exercised in directed runs and in seeded random runs.

// File: rtl/spi_slave_sel.sv
module spi_slave_sel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpol,
  input  logic        cke,
  input  logic [1:0]  wlen,
  input  logic        sel_en,
  input  logic        tx_wr,
  input  logic [31:0] tx_data,
  input  logic        rx_rd,
  input  logic        ovr_clr,
  input  logic        sck,
  input  logic        ss_n,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdo_en,
  output logic [31:0] rx_data,
  output logic        rx_full,
  output logic        rx_ovr,
  output logic        tx_empty
);

  logic [2:0]  sck_q, ss_q, warm;
  logic [1:0]  sdi_q;
  logic [4:0]  cnt, msb;
  logic [31:0] tx_sr, tx_buf, rx_nxt, mask;
  logic [30:0] rx_sr;
  logic        tx_full, from_buf;
  logic        act_now, act_prev, lead, trail, en, samp, chg, start, done, abort, tx_free;

  assign msb      = (wlen == 2'd0) ? 5'd7 : (wlen == 2'd1) ? 5'd15 : 5'd31;
  assign mask     = 32'hFFFF_FFFF >> (5'd31 - msb);
  assign act_now  = sck_q[1] ^ cpol;
  assign act_prev = sck_q[2] ^ cpol;
  assign lead     = warm[2] & act_now & ~act_prev;
  assign trail    = warm[2] & ~act_now & act_prev;
  assign en       = ~sel_en | ~ss_q[1];
  assign samp     = en & (cke ? lead : trail);
  assign chg      = en & (cke ? trail : lead);
  assign start    = samp & (cnt == 5'd0);
  assign done     = samp & (cnt == msb);
  assign abort    = sel_en & ss_q[1] & ~ss_q[2];
  assign tx_free  = tx_full & ((start & ~sel_en) | (done & sel_en & from_buf));
  assign rx_nxt   = {rx_sr, sdi_q[1]};
  assign sdo      = (cnt == 5'd0) ? (tx_full & tx_buf[msb]) : tx_sr[31];
  assign sdo_en   = en;
  assign tx_empty = ~tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm  <= '0;
      sck_q <= '0;
      ss_q  <= '1;
      sdi_q <= '0;
    end else begin
      warm  <= {warm[1:0], 1'b1};
      sck_q <= {sck_q[1:0], sck};
      ss_q  <= {ss_q[1:0], ss_n};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      from_buf <= 1'b0;
    end else begin
      if (abort)
        cnt <= '0;
      else if (samp) begin
        cnt   <= done ? 5'd0 : cnt + 5'd1;
        rx_sr <= rx_nxt[30:0];
      end
      if (start) begin
        tx_sr    <= (tx_full ? tx_buf : 32'd0) << (5'd31 - msb);
        from_buf <= tx_full;
      end else if (chg && cnt != 5'd0)
        tx_sr <= {tx_sr[30:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
    end else if (tx_free)
      tx_full <= 1'b0;
    else if (tx_wr && !tx_full) begin
      tx_full <= 1'b1;
      tx_buf  <= tx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (done && !(rx_full && !rx_rd)) begin
        rx_data <= rx_nxt & mask;
        rx_full <= 1'b1;
      end else if (rx_rd)
        rx_full <= 1'b0;
      if (done && rx_full && !rx_rd)
        rx_ovr <= 1'b1;
      else if (ovr_clr)
        rx_ovr <= 1'b0;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n) cnt <= msb);
  p_sel_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_en && ss_q[1] && $past(ss_q[1]) |=> $stable(cnt));
  p_txe_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) && $past(sel_en) |-> $past(done));
  p_store_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> rx_full);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && rx_full && !rx_rd |=> rx_ovr && $stable(rx_data));

endmodule

// File: tb/spi_slave_sel_bench.sv
`timescale 1ns/1ps
module spi_slave_sel_bench;
  localparam int H = 6;
  logic clk = 0, rst_n = 0;
  logic cpol = 0, cke = 1, sel_en = 0, tx_wr = 0, rx_rd = 0, ovr_clr = 0;
  logic sck = 0, ss_n = 1, sdi = 0;
  logic [1:0] wlen = 0;
  logic [31:0] tx_data = 0;
  logic sdo, sdo_en, rx_full, rx_ovr, tx_empty;
  logic [31:0] rx_data;
  int total = 0, bad = 0;
  bit finished = 0;
  bit m_txfull = 0, m_rxfull = 0, m_ovr = 0;
  logic [31:0] m_txword = 0, m_rxdata = 0;

  spi_slave_sel u_spi_slave_sel (.clk(clk), .rst_n(rst_n), .cpol(cpol), .cke(cke), .wlen(wlen),
    .sel_en(sel_en), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .ovr_clr(ovr_clr),
    .sck(sck), .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en), .rx_data(rx_data),
    .rx_full(rx_full), .rx_ovr(rx_ovr), .tx_empty(tx_empty));

  always #2.5 clk = ~clk;

  function automatic int nbits(input logic [1:0] w);
    return (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
  endfunction
  function automatic logic [31:0] wmask(input logic [1:0] w);
    return 32'hFFFF_FFFF >> (32 - nbits(w));
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic p, input logic e, input logic [1:0] w, input logic s);
    ss_n = 1; sel_en = 1; tick(4);
    cpol = p; sck = p; tick(H);
    cke = e; wlen = w; sel_en = s; tick(4);
  endtask

  task automatic host_wr(input logic [31:0] d);
    tx_data = d; tx_wr = 1; tick(1); tx_wr = 0;
    if (!m_txfull) begin m_txfull = 1; m_txword = d; end
    chk("R9 tx_empty after write", {31'd0, tx_empty}, {31'd0, !m_txfull});
  endtask

  task automatic host_rd();
    rx_rd = 1; tick(1); rx_rd = 0; m_rxfull = 0;
    chk("R11 rx_full after read", {31'd0, rx_full}, 32'd0);
  endtask

  task automatic host_oclr();
    ovr_clr = 1; tick(1); ovr_clr = 0; m_ovr = 0;
    chk("R11 rx_ovr after clear", {31'd0, rx_ovr}, 32'd0);
  endtask

  task automatic edge_wait(input bit last, input bit rdf);
    if (last && rdf) begin
      tick(2); rx_rd = 1; tick(1); rx_rd = 0; tick(H - 3);
    end else tick(H);
  endtask

  task automatic run(input logic [31:0] mo, input int ab, input bit rdf);
    int n = nbits(wlen);
    logic [31:0] mi = 0, exp_mi;
    bit mid_te = 0, txf0 = m_txfull;
    bit aborted = 0;
    int i = 0;
    exp_mi = (m_txfull ? m_txword : 32'd0) & wmask(wlen);
    if (sel_en) begin ss_n = 0; tick(H); end
    while (i < n) begin
      if (!aborted && i == ab) begin
        aborted = 1;
        ss_n = 1; tick(H);
        if (sel_en) begin
          chk("R3 sdo_en off while deselected", {31'd0, sdo_en}, 32'd0);
          repeat (2) begin sck = ~cpol; tick(H); sck = cpol; tick(H); end
          chk("R4 rx_full kept on abort", {31'd0, rx_full}, {31'd0, m_rxfull});
          chk("R4 rx_data kept on abort", rx_data, m_rxdata);
          chk("R5 tx_empty held on abort", {31'd0, tx_empty}, {31'd0, !m_txfull});
          ss_n = 0; tick(H);
          i = 0; mi = 0;
        end else begin
          chk("R6 select ignored", {31'd0, sdo_en}, 32'd1);
          ss_n = 0; tick(H);
        end
      end else begin
        sdi = mo[n - 1 - i];
        if (cke) begin
          tick(H);
          if (i == 1) mid_te = tx_empty;
          mi = {mi[30:0], sdo};
          sck = ~cpol; edge_wait(i == n - 1, rdf);
          sck = cpol;
        end else begin
          sck = ~cpol; tick(H);
          if (i == 1) mid_te = tx_empty;
          mi = {mi[30:0], sdo};
          sck = cpol; edge_wait(i == n - 1, rdf);
        end
        i++;
      end
    end
    tick(H);
    ss_n = 1; tick(H);
    if (rdf) m_rxfull = 0;
    if (m_rxfull) m_ovr = 1;
    else begin m_rxdata = mo & wmask(wlen); m_rxfull = 1; end
    m_txfull = 0;
    chk("R2 R10 slave output word", mi, exp_mi);
    chk("R5 tx_empty mid-word", {31'd0, mid_te}, {31'd0, sel_en ? !txf0 : 1'b1});
    chk("R7 rx_data", rx_data, m_rxdata);
    chk("R7 R8 rx_full", {31'd0, rx_full}, {31'd0, m_rxfull});
    chk("R7 R8 rx_ovr", {31'd0, rx_ovr}, {31'd0, m_ovr});
    chk("R5 tx_empty after word", {31'd0, tx_empty}, 32'd1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    tick(3); rst_n = 1; tick(4);
    chk("R1 reset tx_empty", {31'd0, tx_empty}, 32'd1);
    chk("R1 reset rx_full", {31'd0, rx_full}, 32'd0);
    chk("R1 reset rx_ovr", {31'd0, rx_ovr}, 32'd0);
    chk("R1 reset sdo_en", {31'd0, sdo_en}, 32'd1);

    cfg(0, 1, 2'd0, 0);
    host_wr(32'hA5);
    host_wr(32'h5A);
    run(32'h3C, -1, 0);
    run(32'hC3, -1, 0);
    host_oclr();
    host_rd();

    cfg(1, 0, 2'd1, 0);
    host_wr(32'hBEEF);
    run(32'h1234, 5, 0);

    cfg(0, 0, 2'd2, 1);
    host_rd();
    host_wr(32'hDEADBEEF);
    run(32'hCAFE0123, 9, 0);

    cfg(1, 1, 2'd0, 0);
    host_wr(32'h81);
    run(32'h7E, -1, 1);

    void'($urandom(32'd77));
    for (int k = 0; k < 30; k++) begin
      cfg(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
      if ($urandom % 4 != 0) host_wr($urandom);
      if ($urandom % 3 == 0) host_wr($urandom);
      if ($urandom % 2 == 0 && m_rxfull) host_rd();
      if ($urandom % 3 == 0 && m_ovr) host_oclr();
      run($urandom, ($urandom % 3 == 0) ? int'($urandom % 8) : -1, 0);
    end
    summary();
  end
endmodule